// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Logic

This is the issue-stage decision logic for a two-way in-order superscalar pipeline. Fetch hands it one 64-bit packet each cycle, made of two 32-bit instructions. The left slot may hold any instruction class. The right slot pairs with the left only when it is a floating-point operation. In every cycle the block decides whether no instruction, the left instruction, or both instructions issue. It bases that decision on the slot classes, on a read-after-write dependence between the two slots, and on a scoreboard of load results that are still in flight.

Program order is strict. The right instruction never issues ahead of the left one. If the pair cannot go out together, the left instruction issues first and the right one follows on a later cycle. While any instruction of the packet is still waiting, the block raises a hold towards fetch, and fetch keeps presenting the same packet. A taken branch's shadow reaches the block only through a flush input. Flush discards the held packet and any half-issued state in one cycle.

Top module: `dualIssuePair`

## Requirements
- R1: After reset, with no packet presented, `issueValid` is 00 and `fetchHold` is 0. Reset also clears half-issued state, so the first packet after reset starts at its left slot.
- R2: Instruction encoding: bits [31:30] give the class (00 integer, 01 load, 10 branch, 11 floating point). Bits [29:25] are the destination, bits [24:20] are source A and bits [19:15] are source B. Every class except branch writes its destination. Every class reads source A, and every class except load reads source B. Register 0 never causes a hazard and is never marked pending.
- R3: A packet whose left slot is not floating point and whose right slot is floating point issues both instructions in one cycle (`issueValid`=11, `fetchHold`=0) when no hazard applies.
- R4: `issueValid[1]` (right) is asserted only in a cycle where `issueValid[0]` (left) is also asserted, or after the left instruction of the same packet has already issued.
- R5: When the class mix does not allow pairing (right slot not floating point, or left slot floating point), the left instruction issues alone with `fetchHold`=1. The right instruction issues on the next cycle if nothing blocks it.
- R6: If the right instruction reads a nonzero register that the left instruction writes, the two split across cycles even when their classes would pair.
- R7: A load marks its nonzero destination pending for `LoadDelay` cycles after it issues (default 1). An instruction that reads a pending register does not issue until the mark clears. This covers a consumer in the right slot of the load's own packet and consumers in either slot of the next packet.
- R8: If the left instruction is blocked, neither slot issues (`issueValid`=00, `fetchHold`=1).
- R9: While `flush` is high, nothing issues and `fetchHold` is 0. Any half-issued state is dropped, so the next packet starts at its left slot.
- R10: `fetchHold` is 1 exactly when a valid, unflushed packet still has an instruction that has not issued by the end of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discards the presented packet and half-issued state |
| pktValid | input | 1 | The packet fields carry a real packet |
| pktLeft | input | 32 | Left-slot (older) instruction |
| pktRight | input | 32 | Right-slot (younger) instruction |
| issueValid | output | 2 | Bit 0: left instruction issues this cycle; bit 1: right instruction issues |
| fetchHold | output | 1 | Fetch must present the same packet again next cycle |

## Verification
The main sweep walks every pair of left and right classes. Each pair is tried with four dependence shapes: none, right source A on the left destination, right source B on the left destination, and a register-0 overlap. Together these separate a pairing rule that tests the class mix, one that ignores the class of the source-B reader, and one that wrongly treats register 0 as a dependence. The expected cycle sequence (11, or 01 then 10, with an extra 00 after a load feeding its partner) is computed from the class codes. Directed packets then cover a load feeding either slot of the next packet, a load into register 0, and flush or reset arriving after a half-issued packet. These cases show whether the scoreboard delay, the both-stall rule and the clearing of partial state are each right.

// File: rtl/pairPkg.sv
package pairPkg;
  localparam int InstW = 32;
  localparam int RegW  = 5;

  typedef enum logic [1:0] {
    CLS_INT    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_BRANCH = 2'b10,
    CLS_FP     = 2'b11
  } instClassE;

  typedef struct packed {
    instClassE       cls;
    logic [RegW-1:0] dst;
    logic [RegW-1:0] srcA;
    logic [RegW-1:0] srcB;
    logic [14:0]     spare;
  } instFieldsT;

  // strobes from control to datapath
  typedef struct packed {
    logic issueLeft;
    logic issueRight;
  } issueStrobeT;

  // hazard status from datapath to control
  typedef struct packed {
    logic leftBlocked;
    logic rightBlocked;
    logic rightDepOnLeft;
    logic leftIsFp;
    logic rightIsFp;
  } hazardStatT;

  function automatic logic writesDst(input instFieldsT f);
    return (f.cls != CLS_BRANCH) && (f.dst != '0);
  endfunction

  function automatic logic readsSrcB(input instFieldsT f);
    return f.cls != CLS_LOAD;
  endfunction

  function automatic logic readsReg(input instFieldsT f, input logic [RegW-1:0] r);
    return (r != '0) && ((f.srcA == r) || (readsSrcB(f) && (f.srcB == r)));
  endfunction
endpackage

// File: rtl/pairHazardDp.sv
module pairHazardDp
  import pairPkg::*;
#(
  parameter int LoadDelay = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [InstW-1:0]     pktLeft,
  input  logic [InstW-1:0]     pktRight,
  input  issueStrobeT          strobe,
  output hazardStatT           stat
);
  localparam int NumRegs = 1 << RegW;
  localparam int CntW    = (LoadDelay < 1) ? 1 : $clog2(LoadDelay + 1);

  instFieldsT leftF;
  instFieldsT rightF;
  logic [NumRegs-1:0] pend;
  logic setLeft;
  logic setRight;

  assign leftF  = instFieldsT'(pktLeft);
  assign rightF = instFieldsT'(pktRight);

  assign setLeft  = strobe.issueLeft  && (leftF.cls  == CLS_LOAD) && (leftF.dst  != '0);
  assign setRight = strobe.issueRight && (rightF.cls == CLS_LOAD) && (rightF.dst != '0);

  // per-register pending-load countdown
  for (genvar r = 0; r < NumRegs; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign pend[r] = 1'b0;
    end else begin : g_cnt
      logic [CntW-1:0] cnt;
      logic            hit;
      assign hit = (setLeft  && (leftF.dst  == RegW'(r))) ||
                   (setRight && (rightF.dst == RegW'(r)));
      always_ff @(posedge clk) begin
        if (!rstN)              cnt <= '0;
        else if (hit)           cnt <= CntW'(LoadDelay);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
      assign pend[r] = (cnt != '0);
    end
  end

  function automatic logic srcBusy(input instFieldsT f, input logic [NumRegs-1:0] p);
    return p[f.srcA] || (readsSrcB(f) && p[f.srcB]);
  endfunction

  always_comb begin
    stat.leftBlocked    = srcBusy(leftF, pend);
    stat.rightBlocked   = srcBusy(rightF, pend);
    stat.rightDepOnLeft = writesDst(leftF) && readsReg(rightF, leftF.dst);
    stat.leftIsFp       = (leftF.cls == CLS_FP);
    stat.rightIsFp      = (rightF.cls == CLS_FP);
  end
endmodule

// File: rtl/pairCtrl.sv
module pairCtrl
  import pairPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        pktValid,
  input  hazardStatT  stat,
  output issueStrobeT strobe,
  output logic [1:0]  issueValid,
  output logic        fetchHold
);
  logic leftDone;
  logic canPair;

  assign canPair = !stat.leftIsFp && stat.rightIsFp &&
                   !stat.rightDepOnLeft && !stat.rightBlocked;

  always_comb begin
    strobe    = '0;
    fetchHold = 1'b0;
    if (pktValid && !flush) begin
      if (!leftDone) begin
        strobe.issueLeft  = !stat.leftBlocked;
        strobe.issueRight = !stat.leftBlocked && canPair;
      end else begin
        strobe.issueRight = !stat.rightBlocked;
      end
      // the right slot is always last in the packet
      fetchHold = !strobe.issueRight;
    end
  end

  assign issueValid = {strobe.issueRight, strobe.issueLeft};

  always_ff @(posedge clk) begin
    if (!rstN || flush)          leftDone <= 1'b0;
    else if (strobe.issueRight)  leftDone <= 1'b0;
    else if (strobe.issueLeft)   leftDone <= 1'b1;
  end
endmodule

// File: rtl/dualIssuePair.sv
module dualIssuePair
  import pairPkg::*;
#(
  parameter int LoadDelay = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             pktValid,
  input  logic [31:0]      pktLeft,
  input  logic [31:0]      pktRight,
  output logic [1:0]       issueValid,
  output logic             fetchHold
);
  issueStrobeT strobe;
  hazardStatT  stat;

  pairHazardDp #(.LoadDelay(LoadDelay)) u_dp (
    .clk(clk), .rstN(rstN), .pktLeft(pktLeft), .pktRight(pktRight),
    .strobe(strobe), .stat(stat)
  );

  pairCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .pktValid(pktValid),
    .stat(stat), .strobe(strobe), .issueValid(issueValid), .fetchHold(fetchHold)
  );
endmodule

// File: rtl/dualIssuePairChecker.sv
module dualIssuePairChecker
  import pairPkg::*;
#(
  parameter int LoadDelay = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic        flush,
  input logic        pktValid,
  input logic [31:0] pktLeft,
  input logic [31:0] pktRight,
  input logic [1:0]  issueValid,
  input logic        fetchHold
);
  instFieldsT lf;
  instFieldsT rf;
  logic       seenLeft;
  logic       ldValid;
  logic [RegW-1:0] ldDst;

  assign lf = instFieldsT'(pktLeft);
  assign rf = instFieldsT'(pktRight);

  always_ff @(posedge clk) begin
    if (!rstN || flush)           seenLeft <= 1'b0;
    else if (issueValid[1])       seenLeft <= 1'b0;
    else if (issueValid[0])       seenLeft <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldValid <= 1'b0;
      ldDst   <= '0;
    end else begin
      ldValid <= issueValid[0] && (lf.cls == CLS_LOAD) && (lf.dst != '0) && (LoadDelay >= 1);
      ldDst   <= lf.dst;
    end
  end

  AST_RIGHT_AFTER_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid == 2'b10) |-> seenLeft);  // R4
  AST_PAIR_CLASS_MIX: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid == 2'b11) |-> (rf.cls == CLS_FP && lf.cls != CLS_FP));  // R3
  AST_PAIR_NO_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid == 2'b11) |-> !(writesDst(lf) && readsReg(rf, lf.dst)));  // R6
  AST_LOAD_USE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && readsReg(lf, ldDst)) |-> !issueValid[0]);  // R7
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (issueValid == 2'b00 && !fetchHold));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> (issueValid == 2'b00 && !fetchHold));  // R10
  AST_PARTIAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !flush && !issueValid[1]) |-> fetchHold);  // R10
endmodule

bind dualIssuePair dualIssuePairChecker #(.LoadDelay(LoadDelay)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .pktValid(pktValid),
  .pktLeft(pktLeft), .pktRight(pktRight),
  .issueValid(issueValid), .fetchHold(fetchHold)
);

// File: tb/dualIssuePair_bench.sv
module dualIssuePair_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        pktValid = 1'b0;
  logic [31:0] pktLeft = '0;
  logic [31:0] pktRight = '0;
  logic [1:0]  issueValid;
  logic        fetchHold;
  int          nVec = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dualIssuePair u_dualIssuePair (
    .clk(clk), .rstN(rstN), .flush(flush), .pktValid(pktValid),
    .pktLeft(pktLeft), .pktRight(pktRight),
    .issueValid(issueValid), .fetchHold(fetchHold)
  );

  function automatic logic [31:0] mk(input int cls, input int d, input int a, input int b);
    return {cls[1:0], d[4:0], a[4:0], b[4:0], 15'b0};
  endfunction

  task automatic step(input logic v, input logic fl, input logic [31:0] l, input logic [31:0] r,
                      input logic [1:0] expIss, input logic expHold, input string tag);
    @(negedge clk);
    pktValid = v; flush = fl; pktLeft = l; pktRight = r;
    #5;
    nVec++;
    if (issueValid !== expIss || fetchHold !== expHold) begin
      nBad++;
      $display("FAIL %s: issueValid=%b fetchHold=%b expected issueValid=%b fetchHold=%b",
               tag, issueValid, fetchHold, expIss, expHold);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, '0, 2'b00, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle("R1 reset quiet");
    // half-issue a packet, then reset: partial state must clear
    @(negedge clk); rstN = 1'b1;
    step(1'b1, 1'b0, mk(0,5,1,2), mk(0,9,3,4), 2'b01, 1'b1, "R1 pre-reset split");
    @(negedge clk); rstN = 1'b0; pktValid = 1'b0;
    @(negedge clk); rstN = 1'b1;
    step(1'b1, 1'b0, mk(0,5,1,2), mk(3,9,3,4), 2'b11, 1'b0, "R1 fresh after reset");
    idle("R1 idle");

    // sweep: all class pairs x dependence shapes
    for (int lc = 0; lc < 4; lc++) begin
      for (int rc = 0; rc < 4; rc++) begin
        for (int mode = 0; mode < 4; mode++) begin
          logic [31:0] l;
          logic [31:0] r;
          bit dep;
          bit dual;
          l = mk(lc, (mode == 3) ? 0 : 5, 1, 2);
          case (mode)
            0: r = mk(rc, 9, 3, 4);
            1: r = mk(rc, 9, 5, 4);
            2: r = mk(rc, 9, 3, 5);
            default: r = mk(rc, 9, 0, 4);
          endcase
          dep  = (lc != 2) && (mode == 1 || (mode == 2 && rc != 1));
          dual = (lc != 3) && (rc == 3) && !dep;
          idle("R1 gap");
          idle("R1 gap");
          if (dual) begin
            step(1'b1, 1'b0, l, r, 2'b11, 1'b0, "R3 dual issue");
          end else begin
            step(1'b1, 1'b0, l, r, 2'b01, 1'b1,
                 dep ? "R6 raw split left" : "R5 mix split left");
            if (lc == 1 && dep)
              step(1'b1, 1'b0, l, r, 2'b00, 1'b1, "R7 partner waits on load");
            step(1'b1, 1'b0, l, r, 2'b10, 1'b0, "R4 right follows left");
          end
        end
      end
    end

    // load feeds left slot of next packet: both stall
    idle("R1 gap");
    step(1'b1, 1'b0, mk(1,5,1,0), mk(3,9,3,4), 2'b11, 1'b0, "R3 load+fp pair");
    step(1'b1, 1'b0, mk(0,6,5,2), mk(3,10,3,4), 2'b00, 1'b1, "R8 left load-use stalls both");
    step(1'b1, 1'b0, mk(0,6,5,2), mk(3,10,3,4), 2'b11, 1'b0, "R7 consumer after delay");

    // load feeds right slot of next packet
    idle("R1 gap");
    step(1'b1, 1'b0, mk(1,7,1,0), mk(3,9,3,4), 2'b11, 1'b0, "R3 load+fp pair");
    step(1'b1, 1'b0, mk(0,6,1,2), mk(3,10,7,4), 2'b01, 1'b1, "R7 right consumer held");
    step(1'b1, 1'b0, mk(0,6,1,2), mk(3,10,7,4), 2'b10, 1'b0, "R7 right consumer released");

    // load into register 0 never blocks
    idle("R1 gap");
    step(1'b1, 1'b0, mk(1,0,1,0), mk(3,9,3,4), 2'b11, 1'b0, "R2 load r0 pair");
    step(1'b1, 1'b0, mk(0,6,0,0), mk(3,10,0,0), 2'b11, 1'b0, "R2 r0 readers not held");

    // flush after a half-issued packet
    idle("R1 gap");
    step(1'b1, 1'b0, mk(0,5,1,2), mk(0,9,3,4), 2'b01, 1'b1, "R5 split before flush");
    step(1'b1, 1'b1, mk(0,5,1,2), mk(0,9,3,4), 2'b00, 1'b0, "R9 flush quiet");
    step(1'b1, 1'b0, mk(0,5,1,2), mk(3,9,3,4), 2'b11, 1'b0, "R9 next packet starts left");
    step(1'b1, 1'b1, mk(0,5,1,2), mk(3,9,3,4), 2'b00, 1'b0, "R9 flush on full packet");
    idle("R10 no packet no hold");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule